// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block sits at the output of a stereo sample path. It scales each 24-bit signed left and right sample by a gain that moves by one step on every output frame strobe. Raising the mute request walks the gain from unity down to zero over 1024 frames. Dropping the request walks it back up at the same rate. If the request changes while a ramp is still running, the ramp turns around at its current level and retraces, so there is never a jump in gain.

A mode input chooses manual or semi-auto operation. In manual mode only the mute request steers the ramp. In semi-auto mode the block holds the output at zero for a fixed number of frames after reset, or after a reset-release event. It then starts the unmute ramp by itself, unless the mute request is high at that point. A lost PLL lock forces both outputs to zero for as long as it lasts, and the gain ramp carries on underneath.

Top module: `smute_ramp`

## Requirements
- R1: While rst_ni is low, left_o and right_o are zero, and the gain is zero when reset ends.
- R2: While the effective mute is high, each frame strobe lowers the gain by one, so unity (1024) reaches zero after 1024 strobes.
- R3: While the effective mute is low, each frame strobe raises the gain by one, so zero reaches unity (1024) after 1024 strobes.
- R4: A change of the mute request partway through a ramp reverses the ramp from the current gain, with the same one-step-per-strobe rate.
- R5: The gain saturates at 0 and at 1024, and it does not change in a cycle without a frame strobe or a release event.
- R6: Each output equals floor(sample * gain / 1024), registered one cycle after the sample. Gain 1024 passes the sample unchanged and gain 0 gives exactly zero.
- R7: With semi_auto_i = 1, after reset or a rel_evt_i pulse the gain stays at zero for 4410 frame strobes and rises to 1 on strobe 4411.
- R8: In semi-auto mode, if mute_req_i is high when the 4410-strobe hold ends, the gain stays at zero until the request drops.
- R9: With semi_auto_i = 0 the hold has no effect: after a rel_evt_i pulse, the first strobe with mute_req_i low raises the gain to 1.
- R10: While pll_lock_i is low, both outputs are zero one cycle later, and the gain ramp keeps stepping.
- R11: A rel_evt_i pulse sets the gain to zero at the next clock edge in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mute_req_i | input | 1 | Mute request |
| rel_evt_i | input | 1 | One-cycle pulse marking release from power-down |
| semi_auto_i | input | 1 | 1 = semi-auto mode, 0 = manual mode |
| pll_lock_i | input | 1 | PLL lock status; 0 forces the outputs to zero |
| frame_i | input | 1 | Output frame strobe; one gain step per pulse |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| left_o | output | 24 | Attenuated left sample |
| right_o | output | 24 | Attenuated right sample |

## Verification
The hardest case to reach is the moment the semi-auto hold runs out. It takes thousands of strobes after a release event, and it has to happen once with the mute request low and once with it high. The stimulus strobes a frame on every cycle, so the 4410-frame hold is crossed quickly. The gain is read on either side of the boundary by feeding a sample of 1024, whose output equals the gain. Ramp reversals at chosen mid-levels are reached by directed request toggles. A long run with random strobes, mute toggles, lock drops and release events is then compared every cycle against a bench model.

// File: rtl/smute_pkg.sv
package smute_pkg;
  typedef enum logic {
    MODE_MANUAL = 1'b0,
    MODE_SEMI   = 1'b1
  } smute_mode_e;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_UP   = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/smute_hold.sv
module smute_hold #(
  parameter int HOLD_FRAMES = 4410,
  localparam int CNT_W = $clog2(HOLD_FRAMES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic frame_i,
  output logic hold_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_FRAMES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b1;
      cnt_q  <= '0;
    end else if (restart_i) begin
      hold_o <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_o && frame_i) begin
      if (cnt_q == LAST) hold_o <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  // once expired the hold only comes back through restart
  p_hold_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && !restart_i) |=> !hold_o);
  p_hold_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> hold_o);
  p_hold_no_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !frame_i) |=> hold_o);
endmodule

// File: rtl/smute_gain.sv
module smute_gain
  import smute_pkg::*;
#(
  parameter int RAMP_LEN = 1024,
  localparam int GAIN_W = $clog2(RAMP_LEN) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              frame_i,
  input  logic              mute_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] FULL = GAIN_W'(RAMP_LEN);

  ramp_dir_e dir;

  always_comb begin
    dir = DIR_HOLD;
    if (frame_i) begin
      if (mute_i && gain_o != '0)       dir = DIR_DOWN;
      else if (!mute_i && gain_o != FULL) dir = DIR_UP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_o <= '0;
    end else if (clear_i) begin
      gain_o <= '0;
    end else begin
      unique case (dir)
        DIR_DOWN: gain_o <= gain_o - 1'b1;
        DIR_UP:   gain_o <= gain_o + 1'b1;
        default:  gain_o <= gain_o;
      endcase
    end
  end

  p_gain_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_o <= FULL);
  p_gain_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && !clear_i) |=> $stable(gain_o));
  p_gain_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> gain_o == '0);
  p_gain_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mute_i && !clear_i && gain_o != '0) |=> gain_o < $past(gain_o));
  p_gain_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !mute_i && !clear_i && gain_o != FULL) |=> gain_o > $past(gain_o));
endmodule

// File: rtl/smute_scale.sv
module smute_scale #(
  parameter int SAMPLE_W = 24,
  parameter int SHIFT    = 10,
  localparam int GAIN_W  = SHIFT + 1,
  localparam int PROD_W  = SAMPLE_W + GAIN_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [GAIN_W-1:0]   gain_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam logic [GAIN_W-1:0] FULL = GAIN_W'(1 << SHIFT);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    prod    = $signed(sample_i) * $signed({1'b0, gain_i});
    shifted = prod >>> SHIFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sample_o <= '0;
    else if (!en_i)  sample_o <= '0;
    else             sample_o <= shifted[SAMPLE_W-1:0];
  end

  p_zero_gain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_i == '0) |=> sample_o == '0);
  p_unity_gain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && gain_i == FULL) |=> sample_o == $past(sample_i));
  p_unlock_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> sample_o == '0);
endmodule

// File: rtl/smute_ramp.sv
module smute_ramp
  import smute_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int RAMP_LEN    = 1024,
  parameter int HOLD_FRAMES = 4410,
  localparam int SHIFT  = $clog2(RAMP_LEN),
  localparam int GAIN_W = SHIFT + 1,
  localparam int N_CH   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mute_req_i,
  input  logic                rel_evt_i,
  input  logic                semi_auto_i,
  input  logic                pll_lock_i,
  input  logic                frame_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  smute_mode_e       mode;
  logic              hold;
  logic              mute_eff;
  logic [GAIN_W-1:0] gain;
  logic [SAMPLE_W-1:0] ch_in  [N_CH];
  logic [SAMPLE_W-1:0] ch_out [N_CH];

  assign mode     = smute_mode_e'(semi_auto_i);
  assign mute_eff = mute_req_i || (mode == MODE_SEMI && hold);

  smute_hold #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (rel_evt_i),
    .frame_i   (frame_i),
    .hold_o    (hold)
  );

  smute_gain #(.RAMP_LEN(RAMP_LEN)) u_gain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (rel_evt_i),
    .frame_i (frame_i),
    .mute_i  (mute_eff),
    .gain_o  (gain)
  );

  assign ch_in[0] = left_i;
  assign ch_in[1] = right_i;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    smute_scale #(.SAMPLE_W(SAMPLE_W), .SHIFT(SHIFT)) u_scale (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (pll_lock_i),
      .gain_i   (gain),
      .sample_i (ch_in[ch]),
      .sample_o (ch_out[ch])
    );
  end

  assign left_o  = ch_out[0];
  assign right_o = ch_out[1];

  // semi-auto hold keeps the gain from rising
  p_semi_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (semi_auto_i && hold && !rel_evt_i) |=> gain <= $past(gain));
  p_unlock_both_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_lock_i |=> (left_o == '0 && right_o == '0));
endmodule

// File: tb/smute_ramp_tb.sv
module smute_ramp_tb;
  localparam int  HOLD = 4410;
  localparam int  FULL = 1024;
  localparam longint WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_ni;
  logic mute_req, rel_evt, semi_auto, pll_lock, frame;
  logic [23:0] left_in, right_in;
  logic [23:0] left_out, right_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  int g_m;
  bit hold_m;
  int hcnt_m;

  always #10 clk = ~clk;

  smute_ramp u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mute_req_i(mute_req), .rel_evt_i(rel_evt),
    .semi_auto_i(semi_auto), .pll_lock_i(pll_lock), .frame_i(frame),
    .left_i(left_in), .right_i(right_in), .left_o(left_out), .right_o(right_out)
  );

  function automatic logic [23:0] exp_scale(logic [23:0] s, int g);
    longint p;
    p = longint'($signed(s)) * longint'(g);
    return 24'(p >>> 10);
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  // one clock: inputs already driven at a negedge
  task automatic tick();
    logic [23:0] el, er;
    bit eff;
    el = pll_lock ? exp_scale(left_in, g_m) : 24'd0;
    er = pll_lock ? exp_scale(right_in, g_m) : 24'd0;
    eff = mute_req || (semi_auto && hold_m);
    @(posedge clk);
    @(negedge clk);
    check(cur_req, left_out, el);
    check(cur_req, right_out, er);
    if (rel_evt) begin
      hold_m = 1; hcnt_m = 0;
    end else if (hold_m && frame) begin
      if (hcnt_m == HOLD - 1) hold_m = 0; else hcnt_m++;
    end
    if (rel_evt) g_m = 0;
    else if (frame) begin
      if (eff && g_m > 0) g_m--;
      else if (!eff && g_m < FULL) g_m++;
    end
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) begin
      frame = 1; left_in = $urandom; right_in = $urandom;
      tick();
    end
    frame = 0;
  endtask

  task automatic probe(string req, int exp_g);
    frame = 0; left_in = 24'd1024; right_in = -24'sd1024;
    tick();
    check(req, left_out, 24'(exp_g));
    check(req, right_out, 24'(-exp_g));
  endtask

  task automatic pulse_rel();
    rel_evt = 1; frame = 0; tick(); rel_evt = 0;
  endtask

  initial begin
    #(WATCHDOG * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4127));
    rst_ni = 0; mute_req = 0; rel_evt = 0; semi_auto = 0; pll_lock = 1; frame = 0;
    left_in = 24'h123456; right_in = 24'h800001;
    g_m = 0; hold_m = 1; hcnt_m = 0;
    // R1: outputs zero in reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", left_out, 24'd0);
      check("R1", right_out, 24'd0);
    end
    rst_ni = 1;
    @(negedge clk);
    probe("R1", 0);

    // R3: ramp up in manual mode
    cur_req = "R3";
    frames(1023);
    probe("R3", 1023);
    frames(1);
    probe("R3", 1024);
    // R6: unity passes samples
    cur_req = "R6";
    frame = 0; left_in = 24'h7FFFFF; right_in = 24'hFFFFFF; tick();
    check("R6", left_out, 24'h7FFFFF);
    check("R6", right_out, 24'hFFFFFF);
    frames(5);
    probe("R5", 1024);

    // R2 then R4 reversal
    cur_req = "R2";
    mute_req = 1; frames(500);
    probe("R2", 524);
    cur_req = "R4";
    mute_req = 0; frames(200);
    probe("R4", 724);
    mute_req = 1; frames(100);
    probe("R4", 624);
    cur_req = "R5";
    frames(700);
    probe("R5", 0);
    // R6: zero gain is exact zero, also for negatives
    frame = 0; left_in = 24'h800000; right_in = 24'hFFFFFF; tick();
    check("R6", left_out, 24'd0);
    check("R6", right_out, 24'd0);
    // R5: no strobe, no change
    mute_req = 0;
    for (int i = 0; i < 5; i++) begin
      frame = 0; left_in = $urandom; right_in = $urandom; tick();
    end
    probe("R5", 0);
    frames(3);
    probe("R5", 3);
    // R6: floor rounding at gain 3 of -1
    frame = 0; left_in = 24'hFFFFFF; right_in = 24'd1000; tick();
    check("R6", left_out, 24'hFFFFFF);
    check("R6", right_out, 24'd2);

    // R10: unlock zeroes, ramp continues
    cur_req = "R10";
    frames(1021);
    pll_lock = 0; mute_req = 1;
    frames(10);
    frame = 0; left_in = 24'h400000; right_in = 24'h400000; tick();
    check("R10", left_out, 24'd0);
    pll_lock = 1;
    probe("R10", 1014);

    // R11 / R9: release in manual mode
    cur_req = "R11";
    mute_req = 0;
    pulse_rel();
    probe("R11", 0);
    cur_req = "R9";
    frames(1);
    probe("R9", 1);

    // R7: semi-auto hold
    cur_req = "R7";
    semi_auto = 1;
    pulse_rel();
    probe("R11", 0);
    frames(HOLD);
    probe("R7", 0);
    frames(1);
    probe("R7", 1);

    // R8: mute high at hold expiry
    cur_req = "R8";
    pulse_rel();
    mute_req = 1;
    frames(HOLD + 90);
    probe("R8", 0);
    mute_req = 0;
    frames(5);
    probe("R8", 5);

    // random mix
    cur_req = "R4";
    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(63) == 0) mute_req = ~mute_req;
      pll_lock = ($urandom_range(31) != 0);
      rel_evt  = ($urandom_range(1999) == 0);
      if (rel_evt) semi_auto = $urandom_range(1);
      frame    = $urandom_range(1);
      left_in  = $urandom;
      right_in = $urandom;
      tick();
    end
    rel_evt = 0; pll_lock = 1;
    probe("R4", g_m);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule